// File: doc/BRIEF.md
# Serial-Controlled GPIO Bank

This block is a serial slave that controls a bank of general-purpose pins. A host drives a chip select, a serial clock and a data line, and it reads back on a serial data output. Every transfer opens with an eight-bit command byte. The command byte selects one of three operations: load the configuration register, load the write register, or return the live pin levels. The eight serial clocks after the command carry one data byte, either into the block or out of it.

Each pin gets its mode from two bits, its configuration bit and its write bit. A pin whose configuration bit is clear is an input and is not driven. A pin whose configuration bit is set and whose write bit is clear pulls low in open-drain fashion. A pin with both bits set is driven high. Incoming data first goes to a staging register. It reaches the configuration or write register only when chip select rises at the end of a complete transfer. A host can therefore abandon a transfer without disturbing the pins.

All serial lines are oversampled in the system clock domain. The pin inputs pass through a two-flop synchronizer before the read path takes a copy of them. The control state machine has six states:

- `ST_IDLE`: chip select is high.
- `ST_CMD`: the command bits are shifting in.
- `ST_DATA_IN`: a configuration or write byte is shifting in.
- `ST_DATA_OUT`: the pin byte is shifting out.
- `ST_DONE`: the data byte is complete and the block waits for chip select to rise.
- `ST_IGNORE`: the command was not recognised and the block waits for chip select to rise.

The transitions are:

- From `ST_IDLE` to `ST_CMD` on a falling chip select.
- From `ST_CMD` to `ST_DATA_IN`, `ST_DATA_OUT` or `ST_IGNORE` on the eighth command rising edge, according to the decoded command.
- From `ST_DATA_IN` or `ST_DATA_OUT` to `ST_DONE` on the eighth data rising edge.
- From any state other than `ST_IDLE` back to `ST_IDLE` on a rising chip select. Only when this transition leaves `ST_DONE` after a configuration or write command does it commit the staged byte.

Top module: `gpio_spi_port`

## Requirements
- R1: After reset the configuration and write registers are zero, so every pin is an input with `gpio_oe` = 0 and `gpio_out` = 0.
- R2: The command byte and the data bits are sampled on the rising edge of `spi_sclk`, most significant bit first. Code 0x03 loads the configuration register, 0x02 loads the write register and 0x01 reads the pins.
- R3: A pin whose configuration bit is 0 has `gpio_oe` = 0 and `gpio_out` = 0, whatever its write bit holds.
- R4: A pin with configuration bit 1 and write bit 0 has `gpio_oe` = 1 and `gpio_out` = 0 (open-drain pull low). A pin with both bits 1 has `gpio_oe` = 1 and `gpio_out` = 1.
- R5: The configuration and write registers do not change while `spi_cs_n` is low, even after all eight data bits have arrived. The update takes effect only after `spi_cs_n` rises.
- R6: If `spi_cs_n` rises before the eighth data bit, the transfer is dropped and no register changes.
- R7: A command byte other than 0x01, 0x02 or 0x03 updates nothing, and the bits that follow it are ignored.
- R8: After a read command, `spi_dout` presents the synchronized pin levels most significant bit first. Each bit changes on a falling edge of `spi_sclk`, so the first bit is valid before the first data rising edge.
- R9: `spi_dout_oe` is 1 only while a transfer is in progress, meaning `spi_cs_n` is low. It returns to 0 once `spi_cs_n` is high.
- R10: Serial clocks beyond the eighth data bit are ignored. Only the first data byte is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_din | input | 1 | Serial data from the host |
| spi_dout | output | 1 | Serial data to the host |
| spi_dout_oe | output | 1 | Output enable for `spi_dout`; when it is 0 the pad is high-impedance |
| gpio_in | input | GPIO_W | Pin levels seen at the pads |
| gpio_out | output | GPIO_W | Value driven onto each pin when enabled |
| gpio_oe | output | GPIO_W | Per-pin drive enable |

## Verification
The bench stops a write after all eight data bits and keeps chip select low. A design that commits on the last shifted bit, rather than on the chip select rise, would change the pins early. It also cuts a transfer off after five data bits, and a design that commits a partial byte would corrupt the pins. Unknown commands, including one that differs from the write code only in its top bit, must leave everything untouched; a decoder that compares too few bits would accept them. The bench reads two complementary pin patterns. A design that shifted out on the rising edge, or dropped the first bit, would return a value shifted by one position. The bench also sends a sixteen-bit data phase, which exposes a design that keeps shifting past the first byte. A final pass with mixed input and output pins shows whether write bits leak onto input pins.

// File: rtl/gpio_spi_pkg.sv
package gpio_spi_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CMD_PIN_READ  = 8'h01;
    localparam logic [CMD_W-1:0] CMD_WR_LOAD   = 8'h02;
    localparam logic [CMD_W-1:0] CMD_CFG_LOAD  = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_CMD      = 3'd1,
        ST_DATA_IN  = 3'd2,
        ST_DATA_OUT = 3'd3,
        ST_DONE     = 3'd4,
        ST_IGNORE   = 3'd5
    } fsm_state_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_CFG   = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } port_op_t;

    function automatic port_op_t decode_cmd(input logic [CMD_W-1:0] code);
        port_op_t op;
        unique case (code)
            CMD_CFG_LOAD: op = OP_CFG;
            CMD_WR_LOAD:  op = OP_WRITE;
            CMD_PIN_READ: op = OP_READ;
            default:      op = OP_NONE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/gpio_spi_sync.sv
module gpio_spi_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/gpio_spi_edge.sv
module gpio_spi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sclk_s,
    output logic cs_fall,
    output logic cs_rise,
    output logic sclk_rise,
    output logic sclk_fall
);

    logic cs_n_d;
    logic sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_d <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_n_d <= cs_n_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall   = cs_n_d  & ~cs_n_s;
    assign cs_rise   = ~cs_n_d &  cs_n_s;
    assign sclk_rise = ~sclk_d &  sclk_s & ~cs_n_s;
    assign sclk_fall =  sclk_d & ~sclk_s & ~cs_n_s;

endmodule

// File: rtl/gpio_spi_fsm.sv
module gpio_spi_fsm
    import gpio_spi_pkg::*;
#(
    parameter int GPIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din_s,
    input  logic [GPIO_W-1:0] pins_s,
    output logic [GPIO_W-1:0] cfg_q,
    output logic [GPIO_W-1:0] wr_q,
    output logic              dout,
    output logic              dout_oe,
    output fsm_state_t        state_o
);

    localparam int MAXW  = (CMD_W > GPIO_W) ? CMD_W : GPIO_W;
    localparam int SH_W  = MAXW - 1;
    localparam int CNT_W = $clog2(MAXW);

    fsm_state_t            state_q, state_d;
    port_op_t              op_q;
    port_op_t              next_op;
    logic [CNT_W-1:0]      bit_cnt;
    logic [SH_W-1:0]       in_shift;
    logic [GPIO_W-1:0]     staged_q;
    logic [GPIO_W-1:0]     rd_shift;
    logic                  dout_q;
    logic                  cmd_last;
    logic                  data_last;
    logic                  shifting;

    assign cmd_last  = (bit_cnt == CNT_W'(CMD_W - 1));
    assign data_last = (bit_cnt == CNT_W'(GPIO_W - 1));
    assign next_op   = decode_cmd({in_shift[CMD_W-2:0], din_s});
    assign shifting  = (state_q == ST_CMD) || (state_q == ST_DATA_IN) ||
                       (state_q == ST_DATA_OUT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_rise && (state_q != ST_IDLE)) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_fall) state_d = ST_CMD;
                end
                ST_CMD: begin
                    if (sclk_rise && cmd_last) begin
                        unique case (next_op)
                            OP_CFG, OP_WRITE: state_d = ST_DATA_IN;
                            OP_READ:          state_d = ST_DATA_OUT;
                            default:          state_d = ST_IGNORE;
                        endcase
                    end
                end
                ST_DATA_IN, ST_DATA_OUT: begin
                    if (sclk_rise && data_last) state_d = ST_DONE;
                end
                ST_DONE, ST_IGNORE: state_d = state_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            bit_cnt  <= '0;
            in_shift <= '0;
            staged_q <= '0;
            rd_shift <= '0;
            dout_q   <= 1'b0;
            cfg_q    <= '0;
            wr_q     <= '0;
        end else begin
            if (state_q == ST_IDLE && cs_fall) begin
                bit_cnt <= '0;
                dout_q  <= 1'b0;
                op_q    <= OP_NONE;
            end
            if (shifting && sclk_rise) begin
                in_shift <= {in_shift[SH_W-2:0], din_s};
                if ((state_q == ST_CMD && cmd_last) ||
                    (state_q != ST_CMD && data_last)) begin
                    bit_cnt <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (state_q == ST_CMD && sclk_rise && cmd_last) begin
                op_q <= next_op;
                if (next_op == OP_READ) rd_shift <= pins_s;
            end
            if (state_q == ST_DATA_IN && sclk_rise && data_last) begin
                staged_q <= {in_shift[GPIO_W-2:0], din_s};
            end
            if (state_q == ST_DATA_OUT && sclk_fall) begin
                dout_q   <= rd_shift[GPIO_W-1];
                rd_shift <= {rd_shift[GPIO_W-2:0], 1'b0};
            end
            if (state_q == ST_DONE && cs_rise) begin
                if (op_q == OP_CFG)   cfg_q <= staged_q;
                if (op_q == OP_WRITE) wr_q  <= staged_q;
            end
        end
    end

    assign dout    = dout_q;
    assign dout_oe = (state_q != ST_IDLE);
    assign state_o = state_q;

endmodule

// File: rtl/gpio_spi_pins.sv
module gpio_spi_pins #(
    parameter int GPIO_W = 8
) (
    input  logic [GPIO_W-1:0] cfg_q,
    input  logic [GPIO_W-1:0] wr_q,
    output logic [GPIO_W-1:0] pin_out,
    output logic [GPIO_W-1:0] pin_oe
);

    for (genvar i = 0; i < GPIO_W; i++) begin : g_pin
        always_comb begin
            if (!cfg_q[i]) begin
                pin_oe[i]  = 1'b0;
                pin_out[i] = 1'b0;
            end else if (!wr_q[i]) begin
                pin_oe[i]  = 1'b1;
                pin_out[i] = 1'b0;
            end else begin
                pin_oe[i]  = 1'b1;
                pin_out[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/gpio_spi_port.sv
module gpio_spi_port
    import gpio_spi_pkg::*;
#(
    parameter int GPIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_din,
    output logic              spi_dout,
    output logic              spi_dout_oe,
    input  logic [GPIO_W-1:0] gpio_in,
    output logic [GPIO_W-1:0] gpio_out,
    output logic [GPIO_W-1:0] gpio_oe
);

    logic [2:0]        spi_s;
    logic              cs_s;
    logic              cs_fall, cs_rise, sclk_rise, sclk_fall;
    logic [GPIO_W-1:0] pins_s;
    logic [GPIO_W-1:0] cfg_q, wr_q;
    fsm_state_t        fsm_state;

    assign cs_s = spi_s[2];

    gpio_spi_sync #(.W(3), .RST_VAL(3'b100)) u_spi_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sclk, spi_din}),
        .q     (spi_s)
    );

    gpio_spi_sync #(.W(GPIO_W), .RST_VAL('0)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gpio_in),
        .q     (pins_s)
    );

    gpio_spi_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (spi_s[2]),
        .sclk_s    (spi_s[1]),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    gpio_spi_fsm #(.GPIO_W(GPIO_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din_s     (spi_s[0]),
        .pins_s    (pins_s),
        .cfg_q     (cfg_q),
        .wr_q      (wr_q),
        .dout      (spi_dout),
        .dout_oe   (spi_dout_oe),
        .state_o   (fsm_state)
    );

    gpio_spi_pins #(.GPIO_W(GPIO_W)) u_pins (
        .cfg_q   (cfg_q),
        .wr_q    (wr_q),
        .pin_out (gpio_out),
        .pin_oe  (gpio_oe)
    );

endmodule

// File: rtl/gpio_spi_port_chk.sv
module gpio_spi_port_chk
    import gpio_spi_pkg::*;
#(
    parameter int GPIO_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input logic              cs_fall,
    input logic              cs_rise,
    input logic              sclk_fall,
    input fsm_state_t        fsm_state,
    input logic              spi_dout,
    input logic              spi_dout_oe,
    input logic [GPIO_W-1:0] gpio_out,
    input logic [GPIO_W-1:0] gpio_oe
);

    // R5: pins frozen while chip select stays low
    assert_hold_while_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !$past(cs_s)) |-> ($stable(gpio_oe) && $stable(gpio_out)));

    // R6: a transfer cut off mid data byte commits nothing
    assert_abort_no_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DATA_IN && cs_rise) |=> ($stable(gpio_oe) && $stable(gpio_out)));

    // R7: an unknown command commits nothing
    assert_bad_cmd_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IGNORE && cs_rise) |=> ($stable(gpio_oe) && $stable(gpio_out)));

    // R8: serial output moves only after a falling serial clock or a new frame
    assert_dout_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_dout) |-> ($past(sclk_fall) || $past(cs_fall)));

    // R9: output enable released once chip select is high
    assert_dout_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> !spi_dout_oe);

    // R3: no pin drives high without being enabled
    assert_input_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_out & ~gpio_oe) == '0);

endmodule

bind gpio_spi_port gpio_spi_port_chk #(.GPIO_W(GPIO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_s        (cs_s),
    .cs_fall     (cs_fall),
    .cs_rise     (cs_rise),
    .sclk_fall   (sclk_fall),
    .fsm_state   (fsm_state),
    .spi_dout    (spi_dout),
    .spi_dout_oe (spi_dout_oe),
    .gpio_out    (gpio_out),
    .gpio_oe     (gpio_oe)
);

// File: tb/tb_gpio_spi_port.sv
module tb_gpio_spi_port;

    localparam int CLK_PERIOD = 10;
    localparam int GPIO_W     = 8;
    localparam int HALF       = 6;
    localparam int SETTLE     = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              spi_cs_n = 1'b1;
    logic              spi_sclk = 1'b0;
    logic              spi_din = 1'b0;
    logic              spi_dout;
    logic              spi_dout_oe;
    logic [GPIO_W-1:0] gpio_in = '0;
    logic [GPIO_W-1:0] gpio_out;
    logic [GPIO_W-1:0] gpio_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_spi_port #(.GPIO_W(GPIO_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .spi_sclk    (spi_sclk),
        .spi_din     (spi_din),
        .spi_dout    (spi_dout),
        .spi_dout_oe (spi_dout_oe),
        .gpio_in     (gpio_in),
        .gpio_out    (gpio_out),
        .gpio_oe     (gpio_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic seen);
        spi_din = b;
        wait_clk(HALF);
        seen = spi_dout;
        spi_sclk = 1'b1;
        wait_clk(HALF);
        spi_sclk = 1'b0;
    endtask

    task automatic cs_high();
        spi_cs_n = 1'b1;
        wait_clk(SETTLE);
    endtask

    // sends cmd, then ndata bits of data (MSB first); rd gets the first 8 DOUT samples
    task automatic frame(input logic [7:0] cmd, input logic [15:0] data, input int ndata,
                         input bit release_cs, output logic [7:0] rd);
        logic s;
        rd = '0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 7; i >= 0; i--) send_bit(cmd[i], s);
        for (int i = 0; i < ndata; i++) begin
            send_bit(data[15-i], s);
            if (i < 8) rd[7-i] = s;
        end
        if (release_cs) cs_high();
    endtask

    task automatic test_reset();
        check("R1 oe after reset", gpio_oe, 0);
        check("R1 out after reset", gpio_out, 0);
        check("R9 dout_oe idle", spi_dout_oe, 0);
    endtask

    task automatic test_pulldown();
        logic [7:0] r;
        frame(8'h03, 16'hFF00, 8, 1'b1, r);
        check("R2 R4 cfg load oe", gpio_oe, 8'hFF);
        check("R4 pulldown out", gpio_out, 8'h00);
    endtask

    task automatic test_drive();
        logic [7:0] r;
        frame(8'h02, 16'hA500, 8, 1'b1, r);
        check("R2 R4 driven out", gpio_out, 8'hA5);
        check("R4 oe all", gpio_oe, 8'hFF);
    endtask

    task automatic test_mixed();
        logic [7:0] r;
        frame(8'h03, 16'h0F00, 8, 1'b1, r);
        check("R3 mixed oe", gpio_oe, 8'h0F);
        check("R3 mixed out", gpio_out, 8'h05);
        frame(8'h02, 16'hFF00, 8, 1'b1, r);
        check("R3 write on inputs oe", gpio_oe, 8'h0F);
        check("R3 write on inputs out", gpio_out, 8'h0F);
    endtask

    task automatic test_staging();
        logic [7:0] r;
        frame(8'h02, 16'h0000, 8, 1'b0, r);
        wait_clk(SETTLE);
        check("R5 no update while cs low", gpio_out, 8'h0F);
        check("R9 dout_oe during transfer", spi_dout_oe, 1);
        cs_high();
        check("R5 update after cs rise", gpio_out, 8'h00);
        check("R9 dout_oe after transfer", spi_dout_oe, 0);
    endtask

    task automatic test_abort();
        logic [7:0] r;
        frame(8'h02, 16'hFF00, 5, 1'b1, r);
        check("R6 partial write dropped", gpio_out, 8'h00);
        frame(8'h03, 16'hFF00, 7, 1'b1, r);
        check("R6 partial cfg dropped", gpio_oe, 8'h0F);
    endtask

    task automatic test_bad_cmd();
        logic [7:0] r;
        frame(8'h07, 16'hFF00, 8, 1'b1, r);
        check("R7 cmd 07 out", gpio_out, 8'h00);
        check("R7 cmd 07 oe", gpio_oe, 8'h0F);
        frame(8'h82, 16'hFF00, 8, 1'b1, r);
        check("R7 cmd 82 out", gpio_out, 8'h00);
        frame(8'h00, 16'hFFFF, 16, 1'b1, r);
        check("R7 cmd 00 oe", gpio_oe, 8'h0F);
    endtask

    task automatic test_read();
        logic [7:0] r;
        gpio_in = 8'h3C;
        wait_clk(4);
        frame(8'h01, 16'h0000, 8, 1'b1, r);
        check("R8 read 3C", r, 8'h3C);
        gpio_in = 8'hC3;
        wait_clk(4);
        frame(8'h01, 16'h0000, 8, 1'b1, r);
        check("R8 read C3", r, 8'hC3);
        check("R8 read leaves pins", gpio_out, 8'h00);
    endtask

    task automatic test_extra_bits();
        logic [7:0] r;
        frame(8'h03, 16'hF00F, 16, 1'b1, r);
        check("R10 first byte only oe", gpio_oe, 8'hF0);
        frame(8'h02, 16'h30FF, 16, 1'b1, r);
        check("R10 first byte only out", gpio_out, 8'h30);
        check("R9 dout_oe idle at end", spi_dout_oe, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        test_reset();
        test_pulldown();
        test_drive();
        test_mixed();
        test_staging();
        test_abort();
        test_bad_cmd();
        test_read();
        test_extra_bits();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule